// File: doc/BRIEF.md
# Masked Status-Flag Generator

This block derives integer status flags from a finished micro-operation and folds them into a held flag word. The execution datapath supplies the result it computed, both source operands, the active operand size and a per-operation update mask. On a cycle with the write strobe high, the registered flag word takes freshly computed values in every masked position and keeps its old value everywhere else.

Six architectural flags are produced: carry, parity, nibble (auxiliary) carry, zero, sign and signed overflow. Two shadow flags sit next to them, a spare carry and a spare zero. Each shadow flag repeats the test of its architectural twin but has its own mask bit, so a micro-sequence can update either one alone. For subtract-type operations the caller raises a negate input. The block then evaluates every flag with the two's complement of the second source in its place.

Top module: `ccflag_gen`

## Requirements
- R1: While `rst_ni` is low, `flags_o` is cleared to all zeros.
- R2: On a clock edge where `wr_en_i` is low, `flags_o` keeps its value.
- R3: On a write, each bit of `flags_o` whose `mask_i` bit is 0 keeps its old value. Each bit whose `mask_i` bit is 1 takes the computed flag. Flag positions are: carry 0, parity 2, nibble carry 4, zero 6, sign 7, overflow 11, shadow carry 16, shadow zero 17. A masked position that has no flag is written 0.
- R4: Carry is the carry out of the top bit of the active size, taken from (a AND b) OR ((a OR b) AND NOT r) at that bit. Here a is the first source, b is the effective second source and r is the result.
- R5: Nibble carry is the same carry expression evaluated at bit 3.
- R6: Zero is 1 when the result, truncated to the active size, is 0. Sign is the result bit at the top of the active size.
- R7: Parity is 1 when the low 8 bits of the result hold an even number of ones.
- R8: Overflow is 1 when a and b agree in their top active bit and r differs from them there.
- R9: Shadow carry equals the carry test, and shadow zero equals the zero test. Each is written only under its own mask bit.
- R10: When `neg_b_i` is 1, the effective second source is the 64-bit two's complement of `src_b_i`; otherwise it is `src_b_i`.
- R11: Operand bits above the active size have no effect on any flag.
- R12: `size_i` encodes 0 as 8 bits, 1 as 16 bits, 2 as 32 bits and 3 as 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Write strobe for the flag register |
| size_i | input | 2 | Operand size code |
| neg_b_i | input | 1 | Evaluate flags with the second source negated |
| src_a_i | input | 64 | First source operand |
| src_b_i | input | 64 | Second source operand |
| result_i | input | 64 | Result of the operation |
| mask_i | input | 18 | Per-flag update mask |
| flags_o | output | 18 | Registered flag word |

## Verification
Flag detection is purely combinational, and the only register sits at the output. The merged flag word for a write presented before a rising edge is therefore visible just after that edge, one cycle later. The driver applies each operation on a falling edge and queues the expected word after the following rising edge. The monitor pops the queue and compares on the next falling edge, so every result is sampled half a period after it was due. Idle cycles queue the unchanged word as well, which checks the hold behaviour on the same one-cycle schedule.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int DATA_W  = 64;
  localparam int FLAG_W  = 18;
  localparam int NUM_SZ  = 4;

  localparam int POS_CF  = 0;
  localparam int POS_PF  = 2;
  localparam int POS_AF  = 4;
  localparam int POS_ZF  = 6;
  localparam int POS_SF  = 7;
  localparam int POS_OF  = 11;
  localparam int POS_ECF = 16;
  localparam int POS_EZF = 17;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } opsize_e;

  typedef struct packed {
    logic carry;
    logic nib_carry;
    logic zero;
    logic sign;
    logic ovf;
    logic parity;
  } raw_flags_t;

  // carry out of one bit position, rebuilt from the inputs and the sum bit
  function automatic logic carry_bit(input logic a, input logic b, input logic r);
    return (a & b) | ((a | b) & ~r);
  endfunction

  // signed overflow at one bit position
  function automatic logic ovf_bit(input logic a, input logic b, input logic r);
    return ~(a ^ b) & (a ^ r);
  endfunction

  function automatic logic even_ones8(input logic [7:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/ccf_operand_prep.sv
module ccf_operand_prep
  import ccf_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [1:0]    size_i,
  input  logic          neg_b_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  input  logic [DW-1:0] result_i,
  output logic          a_top_o,
  output logic          b_top_o,
  output logic          r_top_o,
  output logic          r_zero_o,
  output logic [3:0]    a_nib_o,
  output logic [3:0]    b_nib_o,
  output logic [3:0]    r_nib_o,
  output logic [7:0]    r_low_o
);
  logic [DW-1:0] eff_b;
  logic [NUM_SZ-1:0] a_top_v, b_top_v, r_top_v, zero_v;

  assign eff_b = neg_b_i ? (~src_b_i + {{(DW-1){1'b0}}, 1'b1}) : src_b_i;

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_sz
    localparam int W = 8 << g;
    assign a_top_v[g] = src_a_i[W-1];
    assign b_top_v[g] = eff_b[W-1];
    assign r_top_v[g] = result_i[W-1];
    assign zero_v[g]  = (result_i[W-1:0] == '0);
  end

  assign a_top_o  = a_top_v[size_i];
  assign b_top_o  = b_top_v[size_i];
  assign r_top_o  = r_top_v[size_i];
  assign r_zero_o = zero_v[size_i];
  assign a_nib_o  = src_a_i[3:0];
  assign b_nib_o  = eff_b[3:0];
  assign r_nib_o  = result_i[3:0];
  assign r_low_o  = result_i[7:0];
endmodule

// File: rtl/ccf_detect.sv
module ccf_detect
  import ccf_pkg::*;
(
  input  logic       a_top_i,
  input  logic       b_top_i,
  input  logic       r_top_i,
  input  logic       r_zero_i,
  input  logic [3:0] a_nib_i,
  input  logic [3:0] b_nib_i,
  input  logic [3:0] r_nib_i,
  input  logic [7:0] r_low_i,
  output raw_flags_t raw_o
);
  always_comb begin
    raw_o.carry     = carry_bit(a_top_i, b_top_i, r_top_i);
    raw_o.nib_carry = carry_bit(a_nib_i[3], b_nib_i[3], r_nib_i[3]);
    raw_o.zero      = r_zero_i;
    raw_o.sign      = r_top_i;
    raw_o.ovf       = ovf_bit(a_top_i, b_top_i, r_top_i);
    raw_o.parity    = even_ones8(r_low_i);
  end
endmodule

// File: rtl/ccf_merge.sv
module ccf_merge
  import ccf_pkg::*;
#(
  parameter int FW = FLAG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [FW-1:0] mask_i,
  input  logic [FW-1:0] fresh_i,
  output logic [FW-1:0] flags_o
);
  logic [FW-1:0] next_q;

  assign next_q = (flags_o & ~mask_i) | (fresh_i & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_o <= '0;
    else if (wr_en_i) flags_o <= next_q;
  end

  // R2: no strobe, no change
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(flags_o));

  // R3: unmasked positions survive a write
  a_r3_unmasked_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((flags_o & ~$past(mask_i)) == ($past(flags_o) & ~$past(mask_i))));
endmodule

// File: rtl/ccflag_gen.sv
module ccflag_gen
  import ccf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        size_i,
  input  logic              neg_b_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [FLAG_W-1:0] mask_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic       a_top, b_top, r_top, r_zero;
  logic [3:0] a_nib, b_nib, r_nib;
  logic [7:0] r_low;
  raw_flags_t raw;
  logic [FLAG_W-1:0] fresh;

  ccf_operand_prep #(.DW(DATA_W)) prep_i (
    .size_i(size_i), .neg_b_i(neg_b_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
    .result_i(result_i), .a_top_o(a_top), .b_top_o(b_top), .r_top_o(r_top),
    .r_zero_o(r_zero), .a_nib_o(a_nib), .b_nib_o(b_nib), .r_nib_o(r_nib),
    .r_low_o(r_low)
  );

  ccf_detect detect_i (
    .a_top_i(a_top), .b_top_i(b_top), .r_top_i(r_top), .r_zero_i(r_zero),
    .a_nib_i(a_nib), .b_nib_i(b_nib), .r_nib_i(r_nib), .r_low_i(r_low),
    .raw_o(raw)
  );

  always_comb begin
    fresh          = '0;
    fresh[POS_CF]  = raw.carry;
    fresh[POS_PF]  = raw.parity;
    fresh[POS_AF]  = raw.nib_carry;
    fresh[POS_ZF]  = raw.zero;
    fresh[POS_SF]  = raw.sign;
    fresh[POS_OF]  = raw.ovf;
    fresh[POS_ECF] = raw.carry;
    fresh[POS_EZF] = raw.zero;
  end

  ccf_merge #(.FW(FLAG_W)) merge_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .mask_i(mask_i),
    .fresh_i(fresh), .flags_o(flags_o)
  );

  // R9: shadow carry tracks carry when both are written
  a_r9_ecf_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mask_i[POS_CF] && mask_i[POS_ECF]) |=> (flags_o[POS_CF] == flags_o[POS_ECF]));

  // R9: shadow zero tracks zero when both are written
  a_r9_ezf_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mask_i[POS_ZF] && mask_i[POS_EZF]) |=> (flags_o[POS_ZF] == flags_o[POS_EZF]));

  // R6: a zero result never carries a sign
  a_r6_zero_unsigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mask_i[POS_ZF] && mask_i[POS_SF]) |=> !(flags_o[POS_ZF] && flags_o[POS_SF]));
endmodule

// File: tb/ccflag_gen_tb_top.sv
module ccflag_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  size = '0;
  logic        neg_b = 1'b0;
  logic [63:0] a = '0, b = '0, r = '0;
  logic [17:0] mask = '0;
  logic [17:0] flags;

  int checks = 0;
  int errors = 0;
  logic [17:0] model_q = '0;
  logic [17:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  ccflag_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .size_i(size), .neg_b_i(neg_b),
    .src_a_i(a), .src_b_i(b), .result_i(r), .mask_i(mask), .flags_o(flags)
  );

  function automatic logic [17:0] calc(input logic [1:0] sz, input logic sb,
                                       input logic [63:0] x, input logic [63:0] y,
                                       input logic [63:0] res);
    int n;
    logic [63:0] m, ey;
    logic [64:0] s;
    logic [4:0] ns;
    logic [17:0] f;
    n  = 8 << sz;
    m  = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    ey = sb ? (64'd0 - y) : y;
    s  = {1'b0, x & m} + {1'b0, ey & m};
    ns = {1'b0, x[3:0]} + {1'b0, ey[3:0]};
    f  = '0;
    f[0]  = s[n];
    f[16] = s[n];
    f[2]  = ($countones(res[7:0]) % 2) == 0;
    f[4]  = ns[4];
    f[6]  = (res & m) == 0;
    f[17] = (res & m) == 0;
    f[7]  = res[n-1];
    f[11] = (x[n-1] == ey[n-1]) && (res[n-1] != x[n-1]);
    return f;
  endfunction

  task automatic op(input logic [1:0] sz, input logic sb, input logic [63:0] x,
                    input logic [63:0] y, input logic [63:0] res,
                    input logic [17:0] mk, input logic we, input string tag);
    @(negedge clk);
    size = sz; neg_b = sb; a = x; b = y; r = res; mask = mk; wr_en = we;
    if (we) model_q = (model_q & ~mk) | (calc(sz, sb, x, y, res) & mk);
    @(posedge clk);
    #1;
    exp_q.push_back(model_q);
    tag_q.push_back(tag);
  endtask

  function automatic logic [63:0] sum_of(input logic sb, input logic [63:0] x, input logic [63:0] y);
    return sb ? (x - y) : (x + y);
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (flags !== e) begin
          errors++;
          $display("FAIL %s: flags=%h expected=%h", t, flags, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [17:0] ALL = 18'h3FFFF;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (flags !== '0) begin
      errors++;
      $display("FAIL R1: flags=%h expected=%h", flags, 18'h0);
    end
    rst_ni = 1'b1;

    // R4 R5 R6 R7 R9 R12: byte add wrapping to zero
    op(2'd0, 1'b0, 64'hFF, 64'h01, 64'h100, ALL, 1'b1, "R4/R5/R6/R7/R9 byte wrap");
    // R8: byte signed overflow
    op(2'd0, 1'b0, 64'h7F, 64'h01, 64'h80, ALL, 1'b1, "R8 byte overflow");
    // R2: idle cycles hold
    op(2'd0, 1'b0, 64'h0, 64'h0, 64'h0, ALL, 1'b0, "R2 idle hold");
    op(2'd3, 1'b1, 64'h5, 64'h9, 64'h0, ALL, 1'b0, "R2 idle hold");
    // R3: only the zero flag written
    op(2'd0, 1'b0, 64'h10, 64'h01, 64'h11, 18'h00040, 1'b1, "R3 zero-only mask");
    // R3: mask on a position without a flag
    op(2'd0, 1'b0, 64'h0, 64'h0, 64'h0, 18'h00008, 1'b1, "R3 spare position");
    // R10: 16-bit subtract
    op(2'd1, 1'b1, 64'h5, 64'h7, sum_of(1'b1, 64'h5, 64'h7), ALL, 1'b1, "R10 half sub");
    op(2'd1, 1'b1, 64'h8000, 64'h1, sum_of(1'b1, 64'h8000, 64'h1), ALL, 1'b1, "R10/R8 half sub ovf");
    // R11: junk above the word size
    op(2'd2, 1'b0, 64'hDEAD_0000_FFFF_FFFF, 64'hBEEF_0000_0000_0001,
       sum_of(1'b0, 64'hDEAD_0000_FFFF_FFFF, 64'hBEEF_0000_0000_0001), ALL, 1'b1, "R11 word high junk");
    // R12: 64-bit overflow
    op(2'd3, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, ALL, 1'b1, "R12/R8 dword ovf");
    // R9: shadow carry alone
    op(2'd0, 1'b0, 64'hF0, 64'h20, 64'h110, 18'h10000, 1'b1, "R9 shadow carry only");
    op(2'd0, 1'b0, 64'h00, 64'h00, 64'h00, 18'h20000, 1'b1, "R9 shadow zero only");
    // R6 R7: logic-style result, only zero/sign/parity
    op(2'd0, 1'b0, 64'hAA, 64'h55, 64'hC3, 18'h000C4, 1'b1, "R6/R7 logic result");

    // mixed sweep
    for (int i = 0; i < 300; i++) begin
      logic [63:0] x, y;
      logic [1:0] sz;
      logic sb;
      logic [17:0] mk;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
      x = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
      y = (seed[5:0] == 0) ? x : seed;
      sz = seed[9:8];
      sb = seed[10];
      mk = seed[40:23];
      op(sz, sb, x, y, sum_of(sb, x, y), mk, seed[50] | seed[51], "R3/R4/R8/R10/R11 sweep");
    end

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule